// File: doc/BRIEF.md
# Gated Down-Counting Interval Timer Channel

This block is one timer channel with a 16-bit divisor, loaded over a byte-wide write bus with two addresses. Software first writes a control byte to the control address. That byte sets how the divisor bytes arrive and which output shape the channel makes. Software then writes the divisor to the data address as one or two bytes. Once the divisor is complete, the channel counts down once for every cycle of `clk` in which the timer clock enable `tick_en` and the `gate` input are both high. When the count reaches the end of a period, the channel reloads the divisor.

The channel makes two outputs. `tmr_out` is either a square wave or a rate signal that stays high and drops low once per period. `irq_pulse` is high for one `clk` cycle at every reload and can drive an interrupt request line. With a 1,193,180 Hz enable rate, a divisor of 11931 gives a period of roughly 10 ms.

The write bus is a valid/ready stream in which each beat is one byte. `bus_ready` is always high, so the channel never holds back a write. A beat is taken on any `clk` edge where `bus_valid` is high. The timer has no read path.

Top module: `interval_timer_channel`

## Requirements
- R1: After reset, `tmr_out` is 1 and `irq_pulse` is 0. The channel stays idle, with `tmr_out` at 1 and no pulse, until a full divisor has been written.
- R2: `bus_ready` is always 1. Each cycle with `bus_valid` high is one write. `bus_addr`=1 selects the control byte and `bus_addr`=0 selects the divisor data.
- R3: The control byte has four fields. Bits 7:6 are the channel number and must equal `CHANNEL_ID` (0 by default). Bits 5:4 are the byte order. Bits 3:1 are the mode: 010 or 110 selects the rate shape, and 011 or 111 selects the square shape. Bit 0 must be 0. A control byte is ignored completely if the channel differs, if bits 5:4 are 00, if bit 2 is 0, or if bit 0 is 1.
- R4: With byte order 11, the first data write holds the low byte and the second write commits the divisor {high, low}. An accepted control byte sets the next data write back to the low byte and stops the channel, with `tmr_out` at 1, until the next commit.
- R5: While the channel is armed, the count drops by one on each `clk` edge where `tick_en` and `gate` are both 1. While `gate` is 0, the count holds.
- R6: A counting step taken at count 1 reloads the divisor N and raises `irq_pulse` for the next `clk` cycle. The period is therefore N counting steps.
- R7: In the rate shape, `tmr_out` is 0 only while the count equals 1, which lasts one counting step per period.
- R8: In the square shape, `tmr_out` is 1 while the count is above floor(N/2) and 0 otherwise. The high part therefore lasts ceil(N/2) steps and the low part floor(N/2) steps.
- R9: A committed divisor of 0 acts as N = 65536.
- R10: A commit or an accepted control byte takes priority over a counting step in the same cycle. A commit that lands on a terminal step loads the new divisor and raises no `irq_pulse`.
- R11: With byte order 01, each data write commits {0x00, byte}. With byte order 10, each data write commits {byte, 0x00}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Write beat present |
| bus_ready | output | 1 | Always 1: write accepted |
| bus_addr | input | 1 | 1 = control byte, 0 = divisor data |
| bus_wdata | input | DATA_W | Write byte |
| tick_en | input | 1 | Timer clock enable, one count per high cycle |
| gate | input | 1 | Counting allowed while high |
| tmr_out | output | 1 | Waveform output |
| irq_pulse | output | 1 | One-cycle pulse at each reload |

## Verification
The two functions that can land in the same cycle are a divisor commit and the terminal counting step of the period already running. The bench writes the low byte early, then counts its own reference down to 1 and writes the high byte in exactly the cycle whose enabled tick would otherwise reload. It expects the new divisor to be loaded with no `irq_pulse`, and the new period to follow. A control byte written while counting is provoked in the same way. It must stop the channel and hold `tmr_out` high, even while ticks keep arriving.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic {
    WAVE_RATE   = 1'b0,
    WAVE_SQUARE = 1'b1
  } wave_mode_e;

  typedef enum logic [1:0] {
    ORDER_NONE = 2'b00,
    ORDER_LOW  = 2'b01,
    ORDER_HIGH = 2'b10,
    ORDER_PAIR = 2'b11
  } byte_order_e;

  typedef struct packed {
    logic [1:0]  chan;
    byte_order_e order;
    logic [2:0]  mode;
    logic        bcd;
  } ctrl_byte_t;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CHANNEL_ID = 0,
  localparam int DIV_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ctrl_ok,
  output logic              commit,
  output logic [DIV_W-1:0]  div_load,
  output wave_mode_e        wave_mode
);
  ctrl_byte_t        cw;
  byte_order_e       order_q;
  wave_mode_e        mode_q;
  logic              hi_next_q;
  logic [DATA_W-1:0] lo_q;
  logic              data_wr;

  assign cw      = ctrl_byte_t'(wdata[7:0]);
  assign ctrl_ok = wr && (addr == ADDR_CTRL) && (cw.chan == 2'(CHANNEL_ID))
                   && (cw.order != ORDER_NONE) && !cw.bcd && cw.mode[1];
  assign data_wr = wr && (addr == ADDR_DATA);

  always_comb begin
    commit   = 1'b0;
    div_load = '0;
    if (data_wr) begin
      case (order_q)
        ORDER_LOW:  begin commit = 1'b1; div_load = {{DATA_W{1'b0}}, wdata}; end
        ORDER_HIGH: begin commit = 1'b1; div_load = {wdata, {DATA_W{1'b0}}}; end
        ORDER_PAIR: begin commit = hi_next_q; div_load = {wdata, lo_q}; end
        default:    begin commit = 1'b0; div_load = '0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order_q   <= ORDER_PAIR;
      mode_q    <= WAVE_SQUARE;
      hi_next_q <= 1'b0;
      lo_q      <= '0;
    end else if (ctrl_ok) begin
      order_q   <= cw.order;
      mode_q    <= wave_mode_e'(cw.mode[0]);
      hi_next_q <= 1'b0;
    end else if (data_wr && order_q == ORDER_PAIR) begin
      if (!hi_next_q) lo_q <= wdata;
      hi_next_q <= !hi_next_q;
    end
  end

  assign wave_mode = mode_q;
endmodule

// File: rtl/pit_downcount.sv
module pit_downcount #(
  parameter int DIV_W    = 16,
  localparam int CNT_W   = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disarm,
  input  logic             commit,
  input  logic [DIV_W-1:0] div_load,
  input  logic             tick,
  input  logic             gate,
  output logic             armed,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] span,
  output logic             term
);
  logic [CNT_W-1:0] span_new;
  logic             step;

  assign span_new = (div_load == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, div_load};
  assign step     = armed && tick && gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      count <= '0;
      span  <= '0;
      term  <= 1'b0;
    end else begin
      term <= 1'b0;
      if (disarm) begin
        armed <= 1'b0;
      end else if (commit) begin
        span  <= span_new;
        count <= span_new;
        armed <= 1'b1;
      end else if (step) begin
        if (count == CNT_W'(1)) begin
          count <= span;
          term  <= 1'b1;
        end else begin
          count <= count - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pit_shaper.sv
module pit_shaper
  import pit_pkg::*;
#(
  parameter int CNT_W = 17
) (
  input  logic             armed,
  input  wave_mode_e       wave_mode,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] span,
  output logic             wave
);
  always_comb begin
    if (!armed)                      wave = 1'b1;
    else if (wave_mode == WAVE_RATE) wave = (count != CNT_W'(1));
    else                             wave = (count > (span >> 1));
  end
endmodule

// File: rtl/interval_timer_channel.sv
module interval_timer_channel
  import pit_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CHANNEL_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              tick_en,
  input  logic              gate,
  output logic              tmr_out,
  output logic              irq_pulse
);
  localparam int DIV_W = 2 * DATA_W;
  localparam int CNT_W = DIV_W + 1;

  logic             ctrl_ok;
  logic             commit;
  logic [DIV_W-1:0] div_load;
  wave_mode_e       wave_mode;
  logic             armed;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] span;

  assign bus_ready = 1'b1;

  pit_regs #(.DATA_W(DATA_W), .CHANNEL_ID(CHANNEL_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_valid && bus_ready), .addr(bus_addr),
    .wdata(bus_wdata), .ctrl_ok(ctrl_ok), .commit(commit),
    .div_load(div_load), .wave_mode(wave_mode)
  );

  pit_downcount #(.DIV_W(DIV_W)) u_count (
    .clk(clk), .rst_n(rst_n), .disarm(ctrl_ok), .commit(commit),
    .div_load(div_load), .tick(tick_en), .gate(gate), .armed(armed),
    .count(count), .span(span), .term(irq_pulse)
  );

  pit_shaper #(.CNT_W(CNT_W)) u_shape (
    .armed(armed), .wave_mode(wave_mode), .count(count), .span(span),
    .wave(tmr_out)
  );
endmodule

// File: rtl/pit_channel_checker.sv
module pit_channel_checker #(
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate,
  input logic             ctrl_ok,
  input logic             commit,
  input logic             armed,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] span,
  input logic             tmr_out,
  input logic             irq_pulse
);
  AST_IDLE_OUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> tmr_out);  // R1
  AST_CTRL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_ok |=> (!armed && tmr_out));  // R4
  AST_COMMIT_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !ctrl_ok) |=> (armed && count == span));  // R10
  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !gate && !ctrl_ok && !commit) |=> $stable(count));  // R5
  AST_COUNT_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (count != '0 && count <= span));  // R5
  AST_IRQ_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (armed && count == span));  // R6
endmodule

bind interval_timer_channel pit_channel_checker #(.CNT_W(2 * DATA_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate(gate), .ctrl_ok(ctrl_ok), .commit(commit),
  .armed(armed), .count(count), .span(span), .tmr_out(tmr_out),
  .irq_pulse(irq_pulse)
);

// File: tb/test_interval_timer_channel.sv
module test_interval_timer_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0;
  logic       bus_ready;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       tick_en = 1'b0;
  logic       gate = 1'b0;
  logic       tmr_out;
  logic       irq_pulse;

  always #2 clk = ~clk;

  interval_timer_channel i_interval_timer_channel (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tick_en(tick_en),
    .gate(gate), .tmr_out(tmr_out), .irq_pulse(irq_pulse)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit done = 0;

  typedef struct { bit out; bit irq; string req; } exp_t;
  exp_t sb[$];

  // Reference model built from the requirements
  bit m_armed = 0, m_square = 1, m_hi = 0, m_irq = 0;
  int m_order = 3, m_lo = 0, m_span = 0, m_cnt = 0;

  function automatic void model_step(bit v, bit a, int d, bit t, bit g);
    int val;
    bit com = 0;
    m_irq = 0;
    if (v && a) begin
      if (((d >> 6) & 3) == 0 && ((d >> 4) & 3) != 0 && (d & 1) == 0 && ((d >> 2) & 1) == 1) begin
        m_order = (d >> 4) & 3; m_square = (d >> 1) & 1; m_hi = 0; m_armed = 0;
      end else if (m_armed && t && g) begin
        if (m_cnt == 1) begin m_cnt = m_span; m_irq = 1; end else m_cnt--;
      end
      return;
    end
    if (v && !a) begin
      if (m_order == 1) begin com = 1; val = d; end
      else if (m_order == 2) begin com = 1; val = d * 256; end
      else if (!m_hi) begin m_lo = d; m_hi = 1; end
      else begin com = 1; val = d * 256 + m_lo; m_hi = 0; end
    end
    if (com) begin
      m_span = (val == 0) ? 65536 : val; m_cnt = m_span; m_armed = 1;
    end else if (m_armed && t && g) begin
      if (m_cnt == 1) begin m_cnt = m_span; m_irq = 1; end else m_cnt--;
    end
  endfunction

  function automatic bit model_out();
    if (!m_armed) return 1;
    if (!m_square) return m_cnt != 1;
    return m_cnt > m_span / 2;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result
  task automatic cyc(bit v, bit a, int d, bit t, bit g);
    exp_t e;
    bus_valid = v; bus_addr = a; bus_wdata = 8'(d); tick_en = t; gate = g;
    @(posedge clk);
    model_step(v, a, d, t, g);
    e.out = model_out(); e.irq = m_irq; e.req = cur_req;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic run(int n, int tick_mod, int gate_mod);
    for (int i = 0; i < n; i++)
      cyc(0, 0, 0, (i % tick_mod) == 0, gate_mod == 0 || (i % gate_mod) != 0);
  endtask

  // Monitor: pops and compares at the falling edge
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(tmr_out == e.out, e.req, "tmr_out", int'(tmr_out), int'(e.out));
      chk(irq_pulse == e.irq, e.req, "irq_pulse", int'(irq_pulse), int'(e.irq));
    end
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tmr_out == 1'b1, "R1", "reset tmr_out", int'(tmr_out), 1);
    chk(irq_pulse == 1'b0, "R1", "reset irq_pulse", int'(irq_pulse), 0);
    rst_n = 1'b1;
    cur_req = "R1"; run(4, 1, 0);
    chk(bus_ready == 1'b1, "R2", "bus_ready", int'(bus_ready), 1);

    // R3: ignored control bytes leave low-only order and square shape intact
    cur_req = "R3";
    cyc(1, 1, 8'h16, 1, 1);
    cyc(1, 1, 8'h76, 1, 1);
    cyc(1, 1, 8'h17, 1, 1);
    cyc(1, 1, 8'h12, 1, 1);
    cyc(1, 1, 8'h06, 1, 1);
    cur_req = "R11"; cyc(1, 0, 4, 1, 1); run(12, 1, 0);

    // R4: stop on control byte, commit only on high byte
    cur_req = "R4";
    cyc(1, 1, 8'h36, 1, 1);
    cyc(1, 0, 5, 1, 1);
    run(4, 1, 0);
    cyc(1, 0, 0, 1, 1);
    cur_req = "R8"; run(15, 1, 0);
    cyc(1, 1, 8'h36, 1, 1); cyc(1, 0, 6, 1, 1); cyc(1, 0, 0, 1, 1);
    run(14, 1, 0);

    cur_req = "R5"; run(24, 1, 3);

    cur_req = "R7";
    cyc(1, 1, 8'h34, 1, 1); cyc(1, 0, 4, 1, 1); cyc(1, 0, 0, 1, 1);
    run(20, 2, 0);
    cur_req = "R6"; run(12, 1, 0);

    // R10: commit coincides with the terminal tick
    cur_req = "R10";
    cyc(1, 0, 3, 1, 1);
    while (m_cnt != 1) cyc(0, 0, 0, 1, 1);
    cyc(1, 0, 0, 1, 1);
    chk(m_irq == 0 && m_cnt == 3, "R10", "model collision setup", m_cnt, 3);
    run(8, 1, 0);
    while (m_cnt != 1) cyc(0, 0, 0, 1, 1);
    cyc(1, 1, 8'h34, 1, 1);
    run(4, 1, 0);

    cur_req = "R11";
    cyc(1, 1, 8'h24, 1, 1); cyc(1, 0, 1, 1, 1);
    run(520, 1, 0);

    cur_req = "R9";
    cyc(1, 1, 8'h34, 1, 1); cyc(1, 0, 0, 1, 1); cyc(1, 0, 0, 1, 1);
    run(65540, 1, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule